// File: doc/BRIEF.md
# Lockable Watchdog Timer with Keyed Reload

This block is a countdown watchdog for a system that must prove it is still alive. Software first sets a timeout constant and the response modes. It then sets the enable bit and performs one keyed reload. After that reload the counter runs down once per clock. If software does not reload it before it reaches zero, the block raises a watchdog event. The event can request a system reset, raise an interrupt, or do both. Once the watchdog is enabled, software cannot switch it off. Only a power-on reset or a watchdog reset returns it to the off state.

A reload is a two-write key: the feed register receives 0xAA and then 0x55. Idle cycles may separate the two writes, but no other register write may. A broken key is treated as a fault and produces the same event as an expiry. A debug-halt input freezes the countdown and suppresses every event while it is high. A sticky flag records that an event happened. The flag survives the watchdog's own reset and is cleared only by software or by power-on reset.

The control machine has three states. **OFF** goes to **ARMED** on a control write that sets the enable bit. **ARMED** goes to **RUN** on the first valid key. **RUN** goes back to **OFF** on an event while reset mode is set. The key checker has two states. **IDLE** goes to **HALF** on a feed write of 0xAA. **HALF** goes back to **IDLE** on any write: a feed write of 0x55 completes the key, and any other write breaks it.

Top module: `lockwd_top`

## Requirements
- R1: After power-on reset, wd_rst_o, irq_o, flag_o and running_o are 0 and count_o is 0.
- R2: A write to address 0 with bit 0 set enables the watchdog. Writing 0 later does not disable it. The counter stays still and running_o stays 0 until the first valid key arrives. Only a watchdog reset or a power-on reset clears the enable.
- R3: The key is a write of 0xAA to address 2 (only bits 7:0 are compared), then a write of 0x55 to address 2, with any number of idle cycles between them. A completed key loads count_o from the timeout constant. The first completed key after enabling also sets running_o.
- R4: While running and not halted, count_o drops by 1 on each clock. The cycle after count_o reads 0, a watchdog event occurs.
- R5: When reset mode is set (address 0, bit 1; set-only), an event gives a one-cycle pulse on wd_rst_o, clears running_o and sets flag_o in the same cycle.
- R6: irq_o equals flag_o ANDed with interrupt mode (address 0, bit 2; set-only). If reset mode is not set, an event reloads the counter and the watchdog keeps running.
- R7: While running, each of these is a fault with the same effect as an expiry: a feed write whose byte is not 0xAA when no key is open, or any write other than 0x55 to address 2 while a key is open (this includes writes to addresses 0, 1 and 3).
- R8: While dbg_halt is high, count_o holds and no event occurs, whether from expiry or from a bad key.
- R9: flag_o stays set across a watchdog reset. A write to address 0 with bit 3 set clears it. If an event and that clear fall in the same cycle, the flag is set.
- R10: Writing address 1 sets the timeout constant from bits CW-1:0. Any value below 0xFF is stored as 0xFF.
- R11: If a key completes in the same cycle as an expiry would occur, the reload wins: no event occurs and count_o is reloaded.
- R12: While the watchdog is not running, bad keys cause no event and flag_o stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address: 0 control, 1 timeout constant, 2 feed |
| wr_data | input | DW | Write data |
| dbg_halt | input | 1 | Debug halt: freezes the counter and suppresses events |
| wd_rst_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Interrupt level |
| flag_o | output | 1 | Sticky event flag |
| running_o | output | 1 | Watchdog is counting |
| count_o | output | CW | Current counter value |

## Verification
Two events can land on the same clock edge: the second key write and the counter's own expiry. To make them coincide, the bench opens a key and waits until count_o reads zero at a falling edge. It then drives 0x55 so that the write is sampled on exactly the edge where expiry would fire. The bench judges the outcome by a reload to the timeout constant with no flag and no reset pulse. A second collision is a flag clear written in the same cycle as an event. A reference model in the bench covers this case during random traffic and expects the flag to stay set.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } wd_state_t;

    typedef enum logic {
        F_IDLE = 1'b0,
        F_HALF = 1'b1
    } key_state_t;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_TC   = 1;
    localparam int ADDR_FEED = 2;

    localparam logic [7:0] KEY_OPEN  = 8'hAA;
    localparam logic [7:0] KEY_CLOSE = 8'h55;

    localparam int CB_ENABLE = 0;
    localparam int CB_RMODE  = 1;
    localparam int CB_IMODE  = 2;
    localparam int CB_CLEAR  = 3;

endpackage

// File: rtl/lockwd_key.sv
module lockwd_key
    import lockwd_pkg::*;
#(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_key,
    output logic          key_ok,
    output logic          key_bad
);

    key_state_t st_q, st_d;
    logic       is_feed;

    assign is_feed = wr_en && (wr_addr == AW'(ADDR_FEED));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= F_IDLE;
        end else if (clr) begin
            st_q <= F_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        key_ok  = 1'b0;
        key_bad = 1'b0;
        unique case (st_q)
            F_IDLE: begin
                key_bad = is_feed && (wr_key != KEY_OPEN);
                if (is_feed && (wr_key == KEY_OPEN)) begin
                    st_d = F_HALF;
                end
            end
            F_HALF: begin
                key_ok  = is_feed && (wr_key == KEY_CLOSE);
                key_bad = wr_en && !key_ok;
                if (wr_en) begin
                    st_d = F_IDLE;
                end
            end
            default: st_d = F_IDLE;
        endcase
    end

    // R3: a key can only be half-open after a write was seen
    a_r3_open_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == F_HALF && $past(st_q) == F_IDLE) |-> $past(wr_en));

    // R7: a broken key always closes the key
    a_r7_bad_closes: assert property (@(posedge clk) disable iff (!rst_n)
        key_bad |=> (st_q == F_IDLE));

endmodule

// File: rtl/lockwd_ctr.sv
module lockwd_ctr #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] count_o,
    output logic          zero_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count_o = cnt_q;
    assign zero_o  = (cnt_q == '0);

    // R8: with neither load nor decrement the count does not move
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt_q));

    // R4: one step per enabled cycle
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lockwd_top.sv
module lockwd_top
    import lockwd_pkg::*;
#(
    parameter int AW     = 2,
    parameter int DW     = 32,
    parameter int CW     = 24,
    parameter int TC_MIN = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          dbg_halt,
    output logic          wd_rst_o,
    output logic          irq_o,
    output logic          flag_o,
    output logic          running_o,
    output logic [CW-1:0] count_o
);

    localparam logic [CW-1:0] TC_FLOOR = CW'(TC_MIN);

    wd_state_t     state_q, state_d;
    logic [CW-1:0] tc_q;
    logic [CW-1:0] tc_in;
    logic          rmode_q, imode_q, flag_q, rst_q;
    logic          ctrl_wr, tc_wr;
    logic          key_ok, key_bad;
    logic          live, expire, fault, kill;
    logic          ctr_load, ctr_zero;

    assign ctrl_wr = wr_en && (wr_addr == AW'(ADDR_CTRL));
    assign tc_wr   = wr_en && (wr_addr == AW'(ADDR_TC));
    assign tc_in   = wr_data[CW-1:0];

    assign live   = (state_q == ST_RUN) && !dbg_halt;
    assign expire = live && ctr_zero && !key_ok;
    assign fault  = expire || (live && key_bad);
    assign kill   = fault && rmode_q;

    assign ctr_load = (key_ok && (state_q != ST_OFF)) || (fault && !rmode_q);

    lockwd_key #(.AW(AW)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (kill),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_key  (wr_data[7:0]),
        .key_ok  (key_ok),
        .key_bad (key_bad)
    );

    lockwd_ctr #(.CW(CW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (tc_q),
        .dec      (live),
        .count_o  (count_o),
        .zero_o   (ctr_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (ctrl_wr && wr_data[CB_ENABLE]) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (key_ok) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (kill) begin
                    state_d = ST_OFF;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q   <= 1'b0;
            flag_q  <= 1'b0;
            rmode_q <= 1'b0;
            imode_q <= 1'b0;
            tc_q    <= TC_FLOOR;
        end else begin
            rst_q <= kill;
            if (fault) begin
                flag_q <= 1'b1;
            end else if (ctrl_wr && wr_data[CB_CLEAR]) begin
                flag_q <= 1'b0;
            end
            if (ctrl_wr) begin
                rmode_q <= rmode_q | wr_data[CB_RMODE];
                imode_q <= imode_q | wr_data[CB_IMODE];
            end
            if (tc_wr) begin
                tc_q <= (tc_in < TC_FLOOR) ? TC_FLOOR : tc_in;
            end
        end
    end

    assign wd_rst_o  = rst_q;
    assign flag_o    = flag_q;
    assign irq_o     = flag_q && imode_q;
    assign running_o = (state_q == ST_RUN);

    // R5: reset request is a single-cycle pulse
    a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_o |=> !wd_rst_o);

    // R5: reset request coincides with stopped counter and set flag
    a_r5_stop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_o |-> (!running_o && flag_o));

    // R2: leaving ARMED/RUN towards OFF only via a watchdog reset
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_OFF && state_q == ST_OFF) |-> wd_rst_o);

    // R6: interrupt never without the flag
    a_r6_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    // R8: no reset request caused during a halted cycle
    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_o |-> !$past(dbg_halt));

    // R10: stored constant never below the floor
    a_r10_floor: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q >= TC_FLOOR);

endmodule

// File: tb/lockwd_top_tb.sv
module lockwd_top_tb;

    localparam int AW = 2;
    localparam int DW = 32;
    localparam int CW = 24;
    localparam logic [CW-1:0] FLOOR = 24'hFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          halt = 1'b0;
    logic          wd_rst, irq, flag, running;
    logic [CW-1:0] count;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    lockwd_top #(.AW(AW), .DW(DW), .CW(CW), .TC_MIN(255)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (we),
        .wr_addr   (addr),
        .wr_data   (data),
        .dbg_halt  (halt),
        .wd_rst_o  (wd_rst),
        .irq_o     (irq),
        .flag_o    (flag),
        .running_o (running),
        .count_o   (count)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [CW-1:0] clampv(input logic [CW-1:0] v);
        return (v < FLOOR) ? FLOOR : v;
    endfunction

    // reference model, updated from requirements
    int            m_st;
    bit            m_half, m_flag, m_rst, m_rm, m_im;
    logic [CW-1:0] m_cnt, m_tc;

    always @(posedge clk) begin : mdl
        bit isf, cw, fok, fbad, live, evt;
        if (!rst_n) begin
            m_st = 0; m_half = 0; m_cnt = '0; m_tc = FLOOR;
            m_flag = 0; m_rst = 0; m_rm = 0; m_im = 0;
        end else begin
            isf  = we && addr == 2'd2;
            cw   = we && addr == 2'd0;
            fok  = isf && m_half && data[7:0] == 8'h55;
            fbad = m_half ? (we && !fok) : (isf && data[7:0] != 8'hAA);
            live = (m_st == 2) && !halt;
            evt  = live && ((m_cnt == 0 && !fok) || fbad);
            m_rst = evt && m_rm;
            if (fok && m_st != 0) m_cnt = m_tc;
            else if (evt && !m_rm) m_cnt = m_tc;
            else if (live && m_cnt != 0) m_cnt = m_cnt - 1'b1;
            if (evt) m_flag = 1;
            else if (cw && data[3]) m_flag = 0;
            if (m_st == 0 && cw && data[0]) m_st = 1;
            else if (m_st == 1 && fok) m_st = 2;
            else if (m_st == 2 && evt && m_rm) m_st = 0;
            if (evt && m_rm) m_half = 0;
            else if (we) m_half = isf && !m_half && data[7:0] == 8'hAA;
            if (cw) begin m_rm = m_rm | data[1]; m_im = m_im | data[2]; end
            if (we && addr == 2'd1) m_tc = clampv(data[CW-1:0]);
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n && !done) begin
            chk(count == m_cnt, "R4 count", count, m_cnt);
            chk(wd_rst == m_rst, "R5 reset", wd_rst, m_rst);
            chk(irq == (m_flag && m_im), "R6 irq", irq, m_flag && m_im);
            chk(flag == m_flag, "R9 flag", flag, m_flag);
            chk(running == (m_st == 2), "R2 running", running, m_st == 2);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        we = 1'b1; addr = a; data = d;
        @(negedge clk);
        we = 1'b0; data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic por();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic feed();
        wr(2, 32'hAA);
        wr(2, 32'h55);
    endtask

    task automatic rnd(input int n, input bit allow_rm);
        for (int i = 0; i < n; i++) begin
            int r;
            r = $urandom % 64;
            if ($urandom % 40 == 0) halt = ~halt;
            if (r < 4) begin
                wr(2, 32'hAA);
                idle($urandom % 3);
                wr(2, ($urandom % 8 == 0) ? 32'h5A : 32'h55);
            end else if (r < 9) begin
                logic [AW-1:0] a;
                logic [DW-1:0] d;
                a = AW'($urandom % 4);
                d = $urandom;
                if (a == 0) begin
                    d = d & 32'hF;
                    if (!allow_rm) d[1] = 1'b0;
                end else if (a == 1) begin
                    d = 32'h80 + ($urandom % 32'h180);
                end else if (a == 2 && ($urandom % 2 == 0)) begin
                    d = 32'hAA;
                end
                wr(a, d);
            end else begin
                idle(1);
            end
        end
        halt = 1'b0;
    endtask

    initial begin
        logic [CW-1:0] c0;
        void'($urandom(32'd20240611));
        idle(4);
        rst_n = 1'b1;
        idle(1);
        cmp_on = 1'b1;

        // R1: reset state
        chk(wd_rst == 0 && irq == 0 && flag == 0 && running == 0, "R1 outputs", {wd_rst, irq, flag, running}, 0);
        chk(count == 0, "R1 count", count, 0);

        // R12: bad key while off has no effect
        wr(2, 32'h33);
        wr(2, 32'hAA);
        wr(1, 32'h200);
        chk(flag == 0, "R12 flag", flag, 0);

        // R10 + R2: small constant, enable with reset mode, no start before key
        wr(1, 32'h10);
        wr(0, 32'h3);
        idle(5);
        chk(running == 0, "R2 not started", running, 0);
        wr(0, 32'h0);
        chk(count == 0, "R2 count idle", count, 0);

        // R3: key with idle gap
        wr(2, 32'hAA);
        idle(3);
        wr(2, 32'h55);
        chk(running == 1, "R3 running", running, 1);
        chk(count == FLOOR, "R10 clamped load", count, FLOOR);

        // R5: expiry with reset mode
        while (count != 0) @(negedge clk);
        @(negedge clk);
        chk(wd_rst == 1, "R5 pulse", wd_rst, 1);
        chk(running == 0, "R5 stopped", running, 0);
        chk(flag == 1, "R9 set", flag, 1);
        @(negedge clk);
        chk(wd_rst == 0, "R5 pulse width", wd_rst, 0);
        chk(flag == 1, "R9 survives", flag, 1);

        // R9: software clear
        wr(0, 32'h8);
        chk(flag == 0, "R9 clear", flag, 0);

        // interrupt-only configuration
        por();
        wr(1, 32'h120);
        wr(0, 32'h5);
        feed();
        chk(count == 24'h120, "R3 load", count, 24'h120);

        // R7: other register write inside a key
        wr(2, 32'hAA);
        wr(1, 32'h120);
        chk(irq == 1, "R7 interposed write", irq, 1);
        chk(running == 1, "R6 keeps running", running, 1);
        chk(count == 24'h120, "R6 reload", count, 24'h120);
        wr(0, 32'h8);
        chk(irq == 0, "R9 clear irq", irq, 0);

        // R7: wrong first byte
        wr(2, 32'h12);
        chk(irq == 1, "R7 wrong first byte", irq, 1);
        wr(0, 32'h8);

        // R8: halt freezes and suppresses
        halt = 1'b1;
        c0 = count;
        idle(10);
        chk(count == c0, "R8 frozen", count, c0);
        wr(2, 32'h77);
        chk(flag == 0, "R8 bad key suppressed", flag, 0);
        halt = 1'b0;

        // R11: key completes on the expiry edge
        wr(2, 32'hAA);
        while (count != 0) @(negedge clk);
        wr(2, 32'h55);
        chk(count == 24'h120, "R11 reload wins", count, 24'h120);
        chk(flag == 0, "R11 no event", flag, 0);

        // R6: interrupt-only expiry keeps running
        while (count != 0) @(negedge clk);
        @(negedge clk);
        chk(irq == 1, "R6 irq on expiry", irq, 1);
        chk(wd_rst == 0, "R6 no reset", wd_rst, 0);
        chk(running == 1, "R6 still running", running, 1);
        chk(count == 24'h120, "R6 reload on expiry", count, 24'h120);

        // random traffic
        rnd(20000, 1'b0);
        por();
        wr(1, 32'h100);
        wr(0, 32'h7);
        feed();
        rnd(20000, 1'b1);

        idle(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule